// File: doc/BRIEF.md
# Dual-Order Wraparound Burst Address Generator

This block produces the address for each beat of a four-beat memory burst. When an access starts, through either the processor-side strobe or the controller-side strobe, it captures the starting address. From then on it presents the current beat address on every cycle. Each accepted advance moves the two low address bits to the next beat of the burst. All higher address bits stay equal to the captured value for the whole burst.

A static order-select input chooses between two burst orders. The interleaved order takes the starting low bits XOR a two-bit beat count. The linear order takes the starting low bits plus the beat count, modulo four. Both orders are derived from the same two-bit beat counter, which wraps after four advances.

The processor-side strobe counts only while the chip select is active. Advance has no effect on a cycle that loads a new address. A separate suppression input lets the surrounding controller block the advance on any cycle, for example the first cycle of a write that was started by the processor strobe.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and until the first load, `addr` is all zeros.
- R2: A load is accepted at a rising edge when `proc_strobe_n` is 0 and `chip_sel_n` is 0. From the next cycle, `addr` equals `start_addr` and the beat count is zero.
- R3: When `proc_strobe_n` is 0 and `chip_sel_n` is 1, the processor strobe is ignored, and `addr` keeps its previous value unless something else changes it.
- R4: When `ctrl_strobe_n` is 0, a load is accepted whatever the value of `chip_sel_n`.
- R5: On a load edge, `adv_n` is ignored, so the first beat is always the starting address.
- R6: With `interleave` at 0 (linear order), each accepted advance makes the low two bits equal to the captured low two bits plus the beat count, modulo 4.
- R7: With `interleave` at 1 (interleaved order), the low two bits equal the captured low two bits XOR the beat count.
- R8: When `adv_n` is 1 and no load occurs, `addr` holds its value.
- R9: When `adv_block` is 1, an asserted `adv_n` does not move the burst.
- R10: Bits AW-1 down to 2 of `addr` always equal the same bits of the last captured start address.
- R11: After four accepted advances, the beat count wraps and `addr` returns to the starting address.
- R12: A load during a burst restarts the beat count at zero, with the newly captured address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, gated by chip select |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| chip_sel_n | input | 1 | Primary chip select, active low |
| start_addr | input | AW | Burst starting address, captured on load |
| adv_n | input | 1 | Advance request, active low |
| adv_block | input | 1 | When 1, advance is suppressed this cycle |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | output | AW | Current burst address |

## Verification
The hardest case to reach from the ports is a burst in which loads, blocked advances and gated processor strobes fall on cycles that sit between ordinary advances. This matters most when one of these lands on the fourth beat, where the counter wraps. The directed part of the bench sets up each of these cases on purpose: a wrap in each order, a reload in the middle of a burst, a strobe that carries an advance, a strobe that arrives while the chip is deselected, and a blocked advance. A long pseudo-random phase then mixes all the control inputs in both orders. The bench checks every cycle against a behavioural model of the beat count.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 18,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proc_strobe_n,
  input  logic          ctrl_strobe_n,
  input  logic          chip_sel_n,
  input  logic [AW-1:0] start_addr,
  input  logic          adv_n,
  input  logic          adv_block,
  input  logic          interleave,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] base_q;
  logic [CW-1:0] beat_q;
  logic [CW-1:0] low;
  logic          load;
  logic          step;

  assign load = (!proc_strobe_n && !chip_sel_n) || !ctrl_strobe_n;
  assign step = !load && !adv_n && !adv_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= start_addr;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low  = interleave ? (base_q[CW-1:0] ^ beat_q) : (base_q[CW-1:0] + beat_q);
  assign addr = {base_q[AW-1:CW], low};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 18,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          proc_strobe_n,
  input logic          ctrl_strobe_n,
  input logic          chip_sel_n,
  input logic [AW-1:0] start_addr,
  input logic          adv_n,
  input logic          adv_block,
  input logic          interleave,
  input logic [AW-1:0] addr
);

  logic          ld;
  logic          mv;
  logic [AW-1:0] cap_q;

  assign ld = (!proc_strobe_n && !chip_sel_n) || !ctrl_strobe_n;
  assign mv = !adv_n && !adv_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (ld) cap_q <= start_addr;
  end

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> addr == '0 || !rst_n);

  // R2, R4, R5, R12
  a_r5_load_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> addr == $past(start_addr));

  a_r3_gated_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && chip_sel_n && ctrl_strobe_n && !mv && $stable(interleave))
      |=> (addr == $past(addr) || interleave != $past(interleave)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_n) |=> (addr == $past(addr) || interleave != $past(interleave)));

  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv_block) |=> (addr == $past(addr) || interleave != $past(interleave)));

  a_r10_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> addr[AW-1:CW] == cap_q[AW-1:CW]);

  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && mv && !interleave) |=> (interleave || addr[CW-1:0] == $past(addr[CW-1:0]) + 1'b1));

  a_r7_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && mv && interleave) |=>
      (!interleave || (addr[CW-1:0] ^ cap_q[CW-1:0]) == (($past(addr[CW-1:0]) ^ cap_q[CW-1:0]) + 1'b1)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
  .chip_sel_n(chip_sel_n), .start_addr(start_addr), .adv_n(adv_n), .adv_block(adv_block),
  .interleave(interleave), .addr(addr)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_strobe_n = 1'b1;
  logic          ctrl_strobe_n = 1'b1;
  logic          chip_sel_n = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic          adv_n = 1'b1;
  logic          adv_block = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int m_base = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.AW(AW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .chip_sel_n(chip_sel_n), .start_addr(start_addr), .adv_n(adv_n), .adv_block(adv_block),
    .interleave(interleave), .addr(addr)
  );

  function automatic int model_addr();
    int lo;
    lo = m_base % 4;
    if (interleave) lo = lo ^ m_cnt;
    else lo = (lo + m_cnt) % 4;
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: addr=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit ps, input bit cs, input bit cc, input bit av,
                     input bit bl, input bit md, input int sa, input string tag);
    bit ld;
    proc_strobe_n = ps; chip_sel_n = cs; ctrl_strobe_n = cc;
    adv_n = av; adv_block = bl; interleave = md; start_addr = sa[AW-1:0];
    @(posedge clk);
    ld = (!ps && !cs) || !cc;
    if (ld) begin m_base = sa % (1 << AW); m_cnt = 0; end
    else if (!av && !bl) m_cnt = (m_cnt + 1) % 4;
    @(negedge clk);
    check(tag, int'(addr), model_addr());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: addr=%h expected=done", addr);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    int st;
    seed = 7;
    repeat (3) @(negedge clk);
    check("R1", int'(addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(addr), 0);

    // R2 + R5: processor load with advance asserted, linear order
    cyc(0, 0, 1, 0, 0, 0, 18'h2A5E, "R5");
    check("R2", int'(addr), 18'h2A5E);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, 0, 0, 0, "R6");
    check("R10", int'(addr) >> 2, 18'h2A5E >> 2);
    cyc(1, 1, 1, 0, 0, 0, 0, "R11");
    check("R11", int'(addr), 18'h2A5E);
    cyc(1, 1, 1, 0, 0, 0, 0, "R6");
    cyc(1, 1, 1, 1, 0, 0, 0, "R8");
    cyc(1, 0, 1, 1, 0, 0, 0, "R8");
    cyc(1, 1, 1, 0, 1, 0, 0, "R9");
    cyc(0, 1, 1, 1, 0, 0, 18'h1111, "R3");
    cyc(0, 1, 1, 0, 1, 0, 18'h3333, "R3");

    // R4: controller strobe while deselected, interleaved order
    cyc(1, 1, 0, 0, 0, 1, 18'h0C3D, "R4");
    check("R4", int'(addr), 18'h0C3D);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, 0, 1, 0, "R7");
    cyc(1, 1, 1, 0, 0, 1, 0, "R11");
    check("R11", int'(addr), 18'h0C3D);
    cyc(1, 1, 1, 0, 0, 1, 0, "R7");
    cyc(1, 1, 1, 0, 0, 1, 0, "R7");
    cyc(1, 1, 0, 0, 0, 1, 18'h3FFF2, "R12");
    check("R12", int'(addr), 18'h3FFF2);
    cyc(1, 1, 1, 0, 0, 1, 0, "R7");
    check("R10", int'(addr) >> 2, 18'h3FFF2 >> 2);

    for (int i = 0; i < 600; i++) begin
      bit md;
      st = $urandom(seed + i);
      md = st[20];
      cyc(st[3:0] != 0, st[4], st[8:5] != 0, st[9], st[12:10] == 0, md,
          st[AW+12:13], md ? "R7" : "R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule